// File: doc/BRIEF.md
# Segmented Data-Space Address Router

This block sits between an execution unit and the data-side memories of a small controller. Every data request arrives with an addressing mode, a 16-bit address, the current data-segment value, a byte/word size flag and a read/write flag. The router decides which of four targets serves the request: on-chip RAM, external data memory, the built-in special-function registers or the external special-function register window. It also forms the final 24-bit address and produces the byte-lane strobes for the access.

Direct addressing uses only an 11-bit field, which gives a 2 KB direct space. The upper half of that space always holds special-function registers, whatever the segment value. The lower half, and any indirect address that falls inside the on-chip RAM, goes to on-chip RAM only while the segment register is zero. Otherwise it goes to external memory, and the segment value becomes the top byte of the address. A separate external-move input forces a request to external memory even where it overlaps on-chip RAM.

Word accesses are aligned down to an even address and enable both byte lanes. The low byte sits on the even lane (little endian). Results are registered and appear one cycle after the request, together with a valid strobe.

Top module: `seg_router`

## Requirements
- R1: Every output is registered. A request sampled with `req_vld` high appears on the outputs one clock later with `out_vld` high. During reset every output is zero.
- R2: When `out_vld` is high, exactly one of `sel_iram`, `sel_xmem`, `sel_isfr`, `sel_xsfr` is high. When `out_vld` is low, all four are low.
- R3: In direct mode (`req_ind`=0, `req_ext`=0) only address bits [10:0] are used. A field value in 0x400–0x5FF selects `sel_isfr` and a value in 0x600–0x7FF selects `sel_xsfr`, for any `seg_ds`. The output address is the field with the upper byte zero.
- R4: `out_bit` is high only for direct accesses whose field lies in 0x400–0x43F. It is low for every other access.
- R5: An indirect access (`req_ind`=1) never selects either SFR target.
- R6: With `seg_ds` = 0, a direct field below 0x400 and an indirect address below RAM_BYTES both select `sel_iram`. An indirect address at or above RAM_BYTES selects `sel_xmem`.
- R7: With `seg_ds` ≠ 0, direct fields below 0x400 and all indirect addresses select `sel_xmem`.
- R8: For `sel_xmem`, `out_addr`[23:16] equals `seg_ds` and `out_addr`[15:0] is the (aligned) address. For the other targets `out_addr`[23:16] is zero.
- R9: A word access (`req_word`=1) clears address bit 0 and drives `out_be` = 2'b11. Bit 0 of `out_be` is the even (low) byte and bit 1 the odd (high) byte.
- R10: A byte access drives `out_be` = 2'b01 at an even address and 2'b10 at an odd address, and the address is kept as given.
- R11: With `req_ext` = 1 the request selects `sel_xmem` whatever the mode, segment or address.
- R12: `out_wr` and `out_word` repeat the request's write and size flags. Both are zero when `out_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request valid |
| req_ind | input | 1 | 1 = indirect addressing, 0 = direct |
| req_ext | input | 1 | Forced external-memory move |
| req_word | input | 1 | 1 = word access, 0 = byte |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| seg_ds | input | 8 | Data-segment register value |
| out_vld | output | 1 | Routed result valid |
| sel_iram | output | 1 | On-chip RAM selected |
| sel_xmem | output | 1 | External data memory selected |
| sel_isfr | output | 1 | Built-in SFR selected |
| sel_xsfr | output | 1 | External SFR window selected |
| out_bit | output | 1 | Target byte is also bit-addressable |
| out_addr | output | 24 | Final address |
| out_be | output | 2 | Byte-lane strobes (bit 0 even, bit 1 odd) |
| out_wr | output | 1 | Write flag |
| out_word | output | 1 | Word flag |

## Verification
The bench builds the router with RAM_BYTES set to 1024 instead of the default 2048. This moves the indirect on-chip limit below the top of the 11-bit direct space. With segment zero, the indirect addresses 0x3FF and 0x400 then fall on opposite sides of the RAM limit. It also makes an indirect access at 0x600 land in external memory, where a direct access with the same value lands in the external SFR window. The other widths keep their defaults, so the 0x400, 0x440 and 0x600 region edges are tested exactly as specified.

// File: rtl/seg_router.sv
module seg_router #(
  parameter int RAM_BYTES = 2048,
  parameter int AW        = 16,
  parameter int SW        = 8,
  parameter int DIR_W     = 11,
  parameter int BIT_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic             req_ind,
  input  logic             req_ext,
  input  logic             req_word,
  input  logic             req_wr,
  input  logic [AW-1:0]    req_addr,
  input  logic [SW-1:0]    seg_ds,
  output logic             out_vld,
  output logic             sel_iram,
  output logic             sel_xmem,
  output logic             sel_isfr,
  output logic             sel_xsfr,
  output logic             out_bit,
  output logic [AW+SW-1:0] out_addr,
  output logic [1:0]       out_be,
  output logic             out_wr,
  output logic             out_word
);
  localparam int               SFR_LO_I = 1 << (DIR_W - 1);
  localparam logic [DIR_W-1:0] SFR_LO   = DIR_W'(SFR_LO_I);
  localparam logic [DIR_W-1:0] XSFR_LO  = DIR_W'(SFR_LO_I + SFR_LO_I / 2);
  localparam logic [DIR_W-1:0] BIT_END  = DIR_W'(SFR_LO_I + BIT_BYTES);
  localparam logic [AW:0]      RAM_LIM  = (AW+1)'(RAM_BYTES);

  logic [DIR_W-1:0] dfield;
  logic [AW-1:0]    eff, aligned;
  logic             is_dir, seg0, dir_sfr, to_isfr, to_xsfr, to_iram, to_xmem, bitf;
  logic [1:0]       be;

  assign dfield  = req_addr[DIR_W-1:0];
  assign is_dir  = !req_ext && !req_ind;
  assign eff     = is_dir ? AW'(dfield) : req_addr;
  assign aligned = req_word ? {eff[AW-1:1], 1'b0} : eff;
  assign seg0    = (seg_ds == '0);

  assign dir_sfr = is_dir && (dfield >= SFR_LO);
  assign to_isfr = dir_sfr && (dfield < XSFR_LO);
  assign to_xsfr = dir_sfr && !to_isfr;
  assign to_iram = !req_ext && !dir_sfr && seg0 &&
                   (is_dir || ({1'b0, req_addr} < RAM_LIM));
  assign to_xmem = !dir_sfr && !to_iram;
  assign bitf    = to_isfr && (dfield < BIT_END);
  assign be      = req_word ? 2'b11 : (aligned[0] ? 2'b10 : 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n || !req_vld) begin
      out_vld  <= 1'b0;
      sel_iram <= 1'b0;
      sel_xmem <= 1'b0;
      sel_isfr <= 1'b0;
      sel_xsfr <= 1'b0;
      out_bit  <= 1'b0;
      out_addr <= '0;
      out_be   <= 2'b00;
      out_wr   <= 1'b0;
      out_word <= 1'b0;
    end else begin
      out_vld  <= 1'b1;
      sel_iram <= to_iram;
      sel_xmem <= to_xmem;
      sel_isfr <= to_isfr;
      sel_xsfr <= to_xsfr;
      out_bit  <= bitf;
      out_addr <= {(to_xmem ? seg_ds : SW'(0)), aligned};
      out_be   <= be;
      out_wr   <= req_wr;
      out_word <= req_word;
    end
  end
endmodule

// File: rtl/seg_router_chk.sv
module seg_router_chk #(
  parameter int AW = 16,
  parameter int SW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_vld,
  input logic             req_ind,
  input logic             req_ext,
  input logic             out_vld,
  input logic             sel_iram,
  input logic             sel_xmem,
  input logic             sel_isfr,
  input logic             sel_xsfr,
  input logic             out_bit,
  input logic [AW+SW-1:0] out_addr,
  input logic [1:0]       out_be,
  input logic             out_word
);
  // R1
  vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> out_vld);

  // R2
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $countones({sel_iram, sel_xmem, sel_isfr, sel_xsfr}) == 1);

  // R2
  idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> {sel_iram, sel_xmem, sel_isfr, sel_xsfr} == 4'b0);

  // R4
  bit_in_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_bit |-> sel_isfr);

  // R5
  ind_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_ind) |=> !(sel_isfr || sel_xsfr));

  // R9
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_word) |-> (out_addr[0] == 1'b0 && out_be == 2'b11));

  // R11
  ext_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_ext) |=> sel_xmem);

  // R8
  seg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !sel_xmem) |-> out_addr[AW+SW-1:AW] == '0);
endmodule

bind seg_router seg_router_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_ind(req_ind),
  .req_ext(req_ext), .out_vld(out_vld), .sel_iram(sel_iram),
  .sel_xmem(sel_xmem), .sel_isfr(sel_isfr), .sel_xsfr(sel_xsfr),
  .out_bit(out_bit), .out_addr(out_addr), .out_be(out_be),
  .out_word(out_word)
);

// File: tb/sim_seg_router.sv
`timescale 1ns/1ps
module sim_seg_router;
  localparam int RAMB = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0, req_ind = 1'b0, req_ext = 1'b0;
  logic        req_word = 1'b0, req_wr = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  seg_ds = '0;
  logic        out_vld, sel_iram, sel_xmem, sel_isfr, sel_xsfr, out_bit;
  logic [23:0] out_addr;
  logic [1:0]  out_be;
  logic        out_wr, out_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  seg_router #(.RAM_BYTES(RAMB)) u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_ind(req_ind),
    .req_ext(req_ext), .req_word(req_word), .req_wr(req_wr),
    .req_addr(req_addr), .seg_ds(seg_ds), .out_vld(out_vld),
    .sel_iram(sel_iram), .sel_xmem(sel_xmem), .sel_isfr(sel_isfr),
    .sel_xsfr(sel_xsfr), .out_bit(out_bit), .out_addr(out_addr),
    .out_be(out_be), .out_wr(out_wr), .out_word(out_word)
  );

  // packed result: {iram,xmem,isfr,xsfr,bit,addr[23:0],be[1:0],wr,word}
  function automatic logic [32:0] model(logic ind, logic ext, logic word,
                                        logic wr, logic [15:0] a, logic [7:0] ds);
    logic [3:0]  s;
    logic        b;
    logic [15:0] ea;
    logic [23:0] fa;
    logic [1:0]  lanes;
    b = 1'b0;
    ea = (ext || ind) ? a : {5'b0, a[10:0]};
    if (word) ea[0] = 1'b0;
    if (ext) s = 4'b0100;
    else if (!ind && ea >= 16'h600) s = 4'b0001;
    else if (!ind && ea >= 16'h400) begin
      s = 4'b0010;
      b = (ea < 16'h440);
    end
    else if (ds != 0) s = 4'b0100;
    else if (ind && a >= RAMB) s = 4'b0100;
    else s = 4'b1000;
    fa = s[2] ? {ds, ea} : {8'h00, ea};
    lanes = word ? 2'b11 : {ea[0], ~ea[0]};
    return {s, b, fa, lanes, wr, word};
  endfunction

  task automatic send(input logic ind, input logic ext, input logic word,
                      input logic wr, input logic [15:0] a, input logic [7:0] ds,
                      input string tag);
    @(negedge clk);
    req_vld = 1'b1; req_ind = ind; req_ext = ext; req_word = word;
    req_wr = wr; req_addr = a; seg_ds = ds;
    exp_q.push_back(model(ind, ext, word, wr, a, ds));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_vld = 1'b0;
    req_addr = 16'hFFFF;
    seg_ds = 8'hAA;
  endtask

  logic [32:0] got;
  always_comb got = {sel_iram, sel_xmem, sel_isfr, sel_xsfr, out_bit,
                     out_addr, out_be, out_wr, out_word};

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (out_vld) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected result got %h expected none", got);
        end else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (got !== e) begin
            errors++;
            $display("FAIL %s got %h expected %h", t, got, e);
          end
        end
      end else begin
        checks++;
        if (got !== 33'h0) begin
          errors++;
          $display("FAIL R2/R12 idle outputs got %h expected 0", got);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({out_vld, got} !== 34'h0) begin
      errors++;
      $display("FAIL R1 reset state got %h expected 0", {out_vld, got});
    end
    @(negedge clk);
    rst_n = 1'b1;

    send(0, 0, 0, 0, 16'h0123, 8'h00, "R6 direct low seg0");
    send(0, 0, 0, 1, 16'h0123, 8'h05, "R7 direct low seg5");
    idle();
    send(0, 0, 1, 0, 16'h0401, 8'h07, "R3 R9 direct word sfr");
    send(0, 0, 0, 0, 16'h043F, 8'h00, "R4 bit edge in");
    send(0, 0, 0, 0, 16'h0440, 8'h00, "R4 bit edge out");
    send(0, 0, 0, 1, 16'h05FF, 8'h33, "R3 isfr top R10 odd");
    send(0, 0, 0, 0, 16'h0600, 8'h00, "R3 xsfr base");
    send(0, 0, 0, 0, 16'hF9FE, 8'h00, "R3 upper bits ignored R10 even");
    idle();
    send(1, 0, 0, 0, 16'h03FF, 8'h00, "R6 indirect below limit");
    send(1, 0, 0, 0, 16'h0400, 8'h00, "R6 indirect at limit");
    send(1, 0, 0, 0, 16'h0600, 8'h00, "R5 indirect no sfr");
    send(1, 0, 1, 1, 16'h0011, 8'h02, "R7 R8 indirect seg2 word");
    send(0, 1, 0, 0, 16'h0010, 8'h00, "R11 ext move seg0");
    send(0, 1, 1, 1, 16'h0033, 8'h12, "R11 R9 ext word");
    send(0, 1, 0, 0, 16'h0500, 8'h00, "R11 ext over sfr value");
    send(1, 0, 1, 0, 16'hBEEF, 8'hFF, "R8 R12 indirect high");
    idle();
    repeat (3) idle();
    done = 1;
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing results got %0d pending expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    done = 1;
    checks++;
    errors++;
    $display("FAIL R1 watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule